// File: doc/BRIEF.md
# Virtual Interrupt List-Register State Manager

This block keeps a small bank of list registers, one for each virtual interrupt in flight on a virtual CPU. An entry records the virtual interrupt number, the physical interrupt it may be tied to, a 5-bit priority, a 2-bit state (bit 0 pending, bit 1 active), a group bit and a hardware-link bit. A hypervisor fills entries through a load port. The virtual CPU's interface logic then issues commands by interrupt number: it reads the group or priority, clears pending, sets active or clears active.

Commands that come from a physical CPU never touch the bank. They go out unchanged on the distributor port. When a virtual CPU clears the active bit of an entry that has the hardware-link bit set, the block also sends a deactivate to the distributor. That deactivate names the linked physical interrupt and the real CPU behind the virtual one. It is filtered by interrupt range and by security group.

Top module: `vlr_mgr`

## Requirements
- R1: After reset the response and distributor strobes are low, and every entry holds all zero fields: virtual ID 0, state 2'b00 (invalid), priority 0, group 0 and hardware bit 0.
- R2: A virtual command acts on the lowest-indexed entry whose virtual ID equals `cmd_irq`. If no entry matches, the response has `rsp_miss` high and no entry changes.
- R3: Every hit response carries the entry's group bit on `rsp_group`. Op code 3'd0 (read group) changes no field.
- R4: Every hit response carries the stored 5-bit priority shifted left by three on the 8-bit `rsp_prio`. Op code 3'd1 (read priority) changes no field.
- R5: Op code 3'd2 (clear pending) clears state bit 0 only. `rsp_state` shows the updated state.
- R6: Op code 3'd3 (set active) sets state bit 1 only.
- R7: Op code 3'd4 (clear active) clears state bit 1 only. Fields other than the state are never changed by a command.
- R8: A clear-active hit on an entry whose hardware bit is set sends a distributor request with op 3'd4, `dist_irq` equal to the entry's physical ID and `dist_cpu` equal to `cmd_cpu`. It appears in the same cycle as the response.
- R9: No forward is sent when the physical ID is below 16 or at or above `MAX_IRQ` (default 1020).
- R10: While `sec_en` is high, the forward is sent only if `grp_query_is1` reports the physical interrupt, presented on `grp_query_irq`, as group 1.
- R11: A command with `cmd_virt` low is copied to the distributor port (op, ID, CPU). It gives no response and leaves the bank unchanged.
- R12: Every result appears exactly one clock after its command, as a one-cycle strobe. Virtual commands with op codes 3'd5 to 3'd7 produce no output.
- R13: A load with `lr_wr_en` high writes all fields of entry `lr_wr_idx`. The new contents are seen by the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_en | input | 1 | Security extensions enabled |
| lr_wr_en | input | 1 | Load strobe for one entry |
| lr_wr_idx | input | IDX_W | Entry index to load |
| lr_wr_vid | input | 10 | Virtual interrupt ID to load |
| lr_wr_pid | input | 10 | Physical interrupt ID to load |
| lr_wr_prio | input | 5 | Priority to load |
| lr_wr_state | input | 2 | State to load (bit0 pending, bit1 active) |
| lr_wr_grp | input | 1 | Group bit to load |
| lr_wr_hw | input | 1 | Hardware-link bit to load |
| cmd_valid | input | 1 | Command strobe |
| cmd_virt | input | 1 | Command comes from a virtual CPU |
| cmd_op | input | 3 | Operation code |
| cmd_irq | input | 10 | Interrupt ID of the command |
| cmd_cpu | input | CPU_W | Issuing CPU; the backing real CPU for virtual commands |
| grp_query_irq | output | 10 | Physical ID of the matched entry, for the group lookup |
| grp_query_is1 | input | 1 | Distributor: that physical interrupt is in group 1 |
| rsp_valid | output | 1 | Response strobe |
| rsp_miss | output | 1 | No entry matched |
| rsp_group | output | 1 | Group bit of the entry |
| rsp_prio | output | 8 | Priority of the entry, scaled to 8 bits |
| rsp_state | output | 2 | State of the entry after the command |
| dist_valid | output | 1 | Distributor request strobe |
| dist_op | output | 3 | Distributor request op |
| dist_irq | output | 10 | Distributor request interrupt ID |
| dist_cpu | output | CPU_W | Distributor request CPU |

## Verification
The assertions take two things about the inputs for granted. First, `grp_query_is1` answers combinationally for the ID on `grp_query_irq` in the same cycle. Second, a load does not target the entry that a command hits in the same cycle; when both happen, the load wins. The bench models the distributor group as bit 0 of the physical ID. It never loads and commands in the same cycle. The random stimulus draws virtual IDs from a narrow range so that hits, misses and duplicate IDs all occur. It picks physical IDs at and around the range limits.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
    localparam int LR_ID_W   = 10;
    localparam int LR_PRIO_W = 5;
    localparam int PRIO_SH   = 3;
    localparam int PRIO_OUT_W = LR_PRIO_W + PRIO_SH;

    typedef enum logic [2:0] {
        OP_RD_GRP   = 3'd0,
        OP_RD_PRIO  = 3'd1,
        OP_CLR_PEND = 3'd2,
        OP_SET_ACT  = 3'd3,
        OP_CLR_ACT  = 3'd4
    } op_e;

    localparam int PEND_B = 0;
    localparam int ACT_B  = 1;

    typedef struct packed {
        logic [LR_ID_W-1:0]   vid;
        logic [LR_ID_W-1:0]   pid;
        logic [LR_PRIO_W-1:0] prio;
        logic [1:0]           state;
        logic                 grp;
        logic                 hw;
    } lr_t;
endpackage

// File: rtl/vlr_match.sv
module vlr_match
    import vlr_pkg::*;
#(
    parameter int N_LR = 4,
    localparam int IDX_W = $clog2(N_LR)
) (
    input  logic [N_LR-1:0][LR_ID_W-1:0] vids,
    input  logic [LR_ID_W-1:0]           irq,
    output logic                         hit,
    output logic [IDX_W-1:0]             idx
);
    logic [N_LR-1:0] eq;

    for (genvar g = 0; g < N_LR; g++) begin : g_cmp
        assign eq[g] = (vids[g] == irq);
    end

    // lowest index wins: scan downwards so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_LR - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vlr_fwd_filter.sv
module vlr_fwd_filter
    import vlr_pkg::*;
#(
    parameter int SGI_LIM = 16,
    parameter int MAX_IRQ = 1020
) (
    input  logic               hw,
    input  logic [LR_ID_W-1:0] pid,
    input  logic               sec_en,
    input  logic               phys_g1,
    output logic               fwd
);
    localparam logic [LR_ID_W-1:0] LO = LR_ID_W'(SGI_LIM);
    localparam logic [LR_ID_W-1:0] HI = LR_ID_W'(MAX_IRQ);

    logic in_range;
    assign in_range = (pid >= LO) && (pid < HI);
    assign fwd      = hw && in_range && (!sec_en || phys_g1);
endmodule

// File: rtl/vlr_mgr.sv
module vlr_mgr
    import vlr_pkg::*;
#(
    parameter int N_LR    = 4,
    parameter int CPU_W   = 3,
    parameter int SGI_LIM = 16,
    parameter int MAX_IRQ = 1020,
    localparam int IDX_W  = $clog2(N_LR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sec_en,
    input  logic                  lr_wr_en,
    input  logic [IDX_W-1:0]      lr_wr_idx,
    input  logic [LR_ID_W-1:0]    lr_wr_vid,
    input  logic [LR_ID_W-1:0]    lr_wr_pid,
    input  logic [LR_PRIO_W-1:0]  lr_wr_prio,
    input  logic [1:0]            lr_wr_state,
    input  logic                  lr_wr_grp,
    input  logic                  lr_wr_hw,
    input  logic                  cmd_valid,
    input  logic                  cmd_virt,
    input  logic [2:0]            cmd_op,
    input  logic [LR_ID_W-1:0]    cmd_irq,
    input  logic [CPU_W-1:0]      cmd_cpu,
    output logic [LR_ID_W-1:0]    grp_query_irq,
    input  logic                  grp_query_is1,
    output logic                  rsp_valid,
    output logic                  rsp_miss,
    output logic                  rsp_group,
    output logic [PRIO_OUT_W-1:0] rsp_prio,
    output logic [1:0]            rsp_state,
    output logic                  dist_valid,
    output logic [2:0]            dist_op,
    output logic [LR_ID_W-1:0]    dist_irq,
    output logic [CPU_W-1:0]      dist_cpu
);
    typedef struct packed {
        lr_t [N_LR-1:0]        lrs;
        logic                  rsp_valid;
        logic                  rsp_miss;
        logic                  rsp_group;
        logic [PRIO_OUT_W-1:0] rsp_prio;
        logic [1:0]            rsp_state;
        logic                  dist_valid;
        logic [2:0]            dist_op;
        logic [LR_ID_W-1:0]    dist_irq;
        logic [CPU_W-1:0]      dist_cpu;
        logic                  fwd;
    } st_t;

    st_t st_d, st_q;

    logic [N_LR-1:0][LR_ID_W-1:0] vids;
    logic                         m_hit;
    logic [IDX_W-1:0]             m_idx;
    lr_t                          m_ent;
    lr_t                          ent;
    logic                         fwd_ok;
    logic                         op_legal;

    for (genvar g = 0; g < N_LR; g++) begin : g_vid
        assign vids[g] = st_q.lrs[g].vid;
    end

    vlr_match #(.N_LR(N_LR)) u_match (
        .vids (vids),
        .irq  (cmd_irq),
        .hit  (m_hit),
        .idx  (m_idx)
    );

    assign m_ent         = st_q.lrs[m_idx];
    assign grp_query_irq = m_hit ? m_ent.pid : '0;
    assign op_legal      = (cmd_op <= 3'(OP_CLR_ACT));

    vlr_fwd_filter #(.SGI_LIM(SGI_LIM), .MAX_IRQ(MAX_IRQ)) u_filter (
        .hw      (m_ent.hw),
        .pid     (m_ent.pid),
        .sec_en  (sec_en),
        .phys_g1 (grp_query_is1),
        .fwd     (fwd_ok)
    );

    always_comb begin
        st_d            = st_q;
        st_d.rsp_valid  = 1'b0;
        st_d.rsp_miss   = 1'b0;
        st_d.rsp_group  = 1'b0;
        st_d.rsp_prio   = '0;
        st_d.rsp_state  = '0;
        st_d.dist_valid = 1'b0;
        st_d.dist_op    = '0;
        st_d.dist_irq   = '0;
        st_d.dist_cpu   = '0;
        st_d.fwd        = 1'b0;
        ent             = m_ent;

        if (cmd_valid && !cmd_virt) begin
            st_d.dist_valid = 1'b1;
            st_d.dist_op    = cmd_op;
            st_d.dist_irq   = cmd_irq;
            st_d.dist_cpu   = cmd_cpu;
        end else if (cmd_valid && op_legal) begin
            st_d.rsp_valid = 1'b1;
            if (!m_hit) begin
                st_d.rsp_miss = 1'b1;
            end else begin
                unique case (op_e'(cmd_op))
                    OP_CLR_PEND: ent.state[PEND_B] = 1'b0;
                    OP_SET_ACT:  ent.state[ACT_B]  = 1'b1;
                    OP_CLR_ACT: begin
                        ent.state[ACT_B] = 1'b0;
                        if (fwd_ok) begin
                            st_d.dist_valid = 1'b1;
                            st_d.dist_op    = 3'(OP_CLR_ACT);
                            st_d.dist_irq   = m_ent.pid;
                            st_d.dist_cpu   = cmd_cpu;
                            st_d.fwd        = 1'b1;
                        end
                    end
                    default: ;
                endcase
                st_d.lrs[m_idx] = ent;
                st_d.rsp_group  = ent.grp;
                st_d.rsp_prio   = {ent.prio, {PRIO_SH{1'b0}}};
                st_d.rsp_state  = ent.state;
            end
        end

        if (lr_wr_en) begin
            st_d.lrs[lr_wr_idx] = '{vid: lr_wr_vid, pid: lr_wr_pid, prio: lr_wr_prio,
                                    state: lr_wr_state, grp: lr_wr_grp, hw: lr_wr_hw};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_miss   = st_q.rsp_miss;
    assign rsp_group  = st_q.rsp_group;
    assign rsp_prio   = st_q.rsp_prio;
    assign rsp_state  = st_q.rsp_state;
    assign dist_valid = st_q.dist_valid;
    assign dist_op    = st_q.dist_op;
    assign dist_irq   = st_q.dist_irq;
    assign dist_cpu   = st_q.dist_cpu;

    // ---------------- assertions ----------------
    assert_hit_vid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_virt && m_hit) |-> (st_q.lrs[m_idx].vid == cmd_irq));

    assert_miss_keeps_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_miss && !$past(lr_wr_en)) |-> (st_q.lrs == $past(st_q.lrs)));

    assert_clr_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_virt && m_hit && !lr_wr_en && cmd_op == 3'(OP_CLR_PEND))
        |=> (rsp_valid && !rsp_state[PEND_B]));

    assert_set_act_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_virt && m_hit && cmd_op == 3'(OP_SET_ACT))
        |=> (rsp_valid && rsp_state[ACT_B]));

    assert_fwd_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fwd |-> (dist_valid && dist_irq >= LR_ID_W'(SGI_LIM) && dist_irq < LR_ID_W'(MAX_IRQ)));

    assert_secure_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_virt && sec_en && !grp_query_is1) |=> !dist_valid);

    assert_bypass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_virt) |=> (!rsp_valid && dist_valid && dist_irq == $past(cmd_irq)));

    assert_rsp_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && cmd_virt));
endmodule

// File: tb/vlr_mgr_tb.sv
module vlr_mgr_tb;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_en = 1'b0;
    logic lr_wr_en = 1'b0;
    logic [IW-1:0] lr_wr_idx = '0;
    logic [9:0] lr_wr_vid = '0, lr_wr_pid = '0;
    logic [4:0] lr_wr_prio = '0;
    logic [1:0] lr_wr_state = '0;
    logic lr_wr_grp = 1'b0, lr_wr_hw = 1'b0;
    logic cmd_valid = 1'b0, cmd_virt = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [9:0] cmd_irq = '0;
    logic [CW-1:0] cmd_cpu = '0;
    logic [9:0] grp_query_irq;
    logic grp_query_is1;
    logic rsp_valid, rsp_miss, rsp_group;
    logic [7:0] rsp_prio;
    logic [1:0] rsp_state;
    logic dist_valid;
    logic [2:0] dist_op;
    logic [9:0] dist_irq;
    logic [CW-1:0] dist_cpu;

    always #2 clk = ~clk;

    // distributor model: physical group 1 when bit 0 of the ID is set
    function automatic logic phys_g1(input logic [9:0] id);
        return id[0];
    endfunction
    always_comb grp_query_is1 = phys_g1(grp_query_irq);

    vlr_mgr u_dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [9:0] m_vid [N], m_pid [N];
    logic [4:0] m_prio [N];
    logic [1:0] m_st [N];
    logic       m_grp [N], m_hw [N];

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load(input int idx, input int vid, input int pid, input int prio,
                        input int st, input int grp, input int hw);
        @(negedge clk);
        lr_wr_en = 1'b1; lr_wr_idx = IW'(idx); lr_wr_vid = 10'(vid); lr_wr_pid = 10'(pid);
        lr_wr_prio = 5'(prio); lr_wr_state = 2'(st); lr_wr_grp = grp[0]; lr_wr_hw = hw[0];
        @(negedge clk);
        lr_wr_en = 1'b0;
        m_vid[idx] = 10'(vid); m_pid[idx] = 10'(pid); m_prio[idx] = 5'(prio);
        m_st[idx] = 2'(st); m_grp[idx] = grp[0]; m_hw[idx] = hw[0];
    endtask

    task automatic cmd(input logic virt, input int op, input int irq, input int cpu, input string req);
        int hit;
        logic [1:0] ns;
        logic efwd;
        hit = -1;
        for (int i = N - 1; i >= 0; i--) if (m_vid[i] == 10'(irq)) hit = i;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_virt = virt; cmd_op = 3'(op); cmd_irq = 10'(irq); cmd_cpu = CW'(cpu);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!virt) begin
            chk(req, "bypass rsp_valid", int'(rsp_valid), 0);
            chk(req, "bypass dist_valid", int'(dist_valid), 1);
            chk(req, "bypass dist_op", int'(dist_op), op);
            chk(req, "bypass dist_irq", int'(dist_irq), irq);
            chk(req, "bypass dist_cpu", int'(dist_cpu), cpu);
        end else if (op > 4) begin
            chk(req, "illegal op rsp_valid", int'(rsp_valid), 0);
            chk(req, "illegal op dist_valid", int'(dist_valid), 0);
        end else if (hit < 0) begin
            chk(req, "miss rsp_valid", int'(rsp_valid), 1);
            chk(req, "miss flag", int'(rsp_miss), 1);
            chk(req, "miss dist_valid", int'(dist_valid), 0);
        end else begin
            ns = m_st[hit];
            if (op == 2) ns[0] = 1'b0;
            if (op == 3) ns[1] = 1'b1;
            if (op == 4) ns[1] = 1'b0;
            efwd = (op == 4) && m_hw[hit] && m_pid[hit] >= 10'd16 && m_pid[hit] < 10'd1020 &&
                   (!sec_en || phys_g1(m_pid[hit]));
            chk(req, "rsp_valid", int'(rsp_valid), 1);
            chk(req, "rsp_miss", int'(rsp_miss), 0);
            chk(req, "rsp_state", int'(rsp_state), int'(ns));
            chk("R3", "rsp_group", int'(rsp_group), int'(m_grp[hit]));
            chk("R4", "rsp_prio", int'(rsp_prio), int'(m_prio[hit]) * 8);
            chk(req, "dist_valid", int'(dist_valid), int'(efwd));
            if (efwd) begin
                chk("R8", "fwd dist_op", int'(dist_op), 4);
                chk("R8", "fwd dist_irq", int'(dist_irq), int'(m_pid[hit]));
                chk("R8", "fwd dist_cpu", int'(dist_cpu), cpu);
            end
            m_st[hit] = ns;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vid[i] = '0; m_pid[i] = '0; m_prio[i] = '0; m_st[i] = '0; m_grp[i] = 1'b0; m_hw[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk("R1", "dist_valid after reset", int'(dist_valid), 0);
        cmd(1'b1, 0, 0, 0, "R1");

        // loads and plain reads (R13, R3, R4)
        load(0, 40, 100, 21, 1, 1, 0);
        load(1, 50, 200, 7, 3, 0, 1);
        load(2, 60, 15, 31, 2, 1, 1);
        load(3, 50, 300, 3, 1, 1, 0);
        cmd(1'b1, 0, 40, 1, "R13");
        cmd(1'b1, 1, 60, 1, "R4");
        // state edits
        cmd(1'b1, 2, 40, 1, "R5");
        cmd(1'b1, 3, 40, 1, "R6");
        cmd(1'b1, 4, 40, 1, "R7");
        // duplicate vid 50: entry 1 wins; entry 3 seen after entry 1 renamed (R2)
        cmd(1'b1, 2, 50, 2, "R2");
        load(1, 51, 200, 7, 3, 0, 1);
        cmd(1'b1, 0, 50, 2, "R2");
        // miss leaves bank untouched
        cmd(1'b1, 3, 99, 0, "R2");
        cmd(1'b1, 0, 40, 0, "R2");
        // forward boundaries (R8, R9)
        cmd(1'b1, 4, 60, 5, "R9");
        load(2, 60, 16, 4, 2, 0, 1);
        cmd(1'b1, 4, 60, 5, "R8");
        load(2, 60, 1019, 4, 2, 0, 1);
        cmd(1'b1, 4, 60, 6, "R8");
        load(2, 60, 1020, 4, 2, 0, 1);
        cmd(1'b1, 4, 60, 6, "R9");
        // security filter (R10)
        sec_en = 1'b1;
        load(2, 60, 16, 4, 2, 0, 1);
        cmd(1'b1, 4, 60, 3, "R10");
        load(2, 60, 17, 4, 2, 0, 1);
        cmd(1'b1, 4, 60, 3, "R10");
        sec_en = 1'b0;
        // bypass and illegal codes (R11, R12)
        cmd(1'b0, 4, 60, 2, "R11");
        cmd(1'b1, 0, 60, 2, "R11");
        cmd(1'b1, 6, 60, 2, "R12");

        // constrained random
        void'($urandom(32'd1357));
        for (int k = 0; k < 500; k++) begin
            sec_en = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 4) == 0) begin
                int pid;
                case ($urandom_range(0, 4))
                    0: pid = $urandom_range(14, 17);
                    1: pid = $urandom_range(1018, 1023);
                    default: pid = $urandom_range(0, 1023);
                endcase
                load($urandom_range(0, N - 1), $urandom_range(40, 45), pid, $urandom_range(0, 31),
                     $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 1));
            end else begin
                int op;
                op = ($urandom_range(0, 19) == 0) ? $urandom_range(5, 7) : $urandom_range(0, 4);
                cmd($urandom_range(0, 6) != 0, op, $urandom_range(40, 46), $urandom_range(0, 7),
                    op == 4 ? "R8" : op == 3 ? "R6" : op == 2 ? "R5" : "R12");
            end
        end
        finish_run();
    end
endmodule